// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside the program counter logic of a small 8-bit core and decides which of its interrupt sources is served next. Each source has a pending flag and its own enable bit, and one global enable gates them all. Event sources set a flag that stays set until the core takes that source or software clears it. Level sources have no flag and ask for service only while their input is high. The lowest source index always wins.

The core sees a request line. It answers with a one-cycle acknowledge and then reads a registered vector address. Taking an interrupt clears the global enable. When the core reports a return from an interrupt, the global enable comes back on. After that return, no new request is raised until the core has finished at least one more instruction in a later cycle. A control bit moves the interrupt vectors from the bottom of program memory to an alternate base that is set by a parameter.

Top module: `irq_vector_unit`

## Requirements
- R1: `irqReq` is high only when some source is pending, its enable bit is 1, the global enable is 1 and no post-return holdoff is active.
- R2: Source i maps to vector `base + ENTRY_WORDS*(i+1)`, with slot 0 of the table kept for reset. When several sources qualify, the lowest index is the one served. The vector is loaded into `vecAddr` at the clock edge where `irqAck` is high while `irqReq` is high.
- R3: `base` is 0 when control bit 1 (register 2) is 0 and `ALT_BASE` when it is 1. The value of the bit in the acknowledge cycle is the one used.
- R4: Taking an interrupt clears the global enable, which is control bit 0 (register 2), from the next cycle on. Software can set it again by writing register 2.
- R5: A `retiDone` pulse sets the global enable. It takes priority over a software write to register 2 in the same cycle, and an acknowledge in the same cycle overrides it.
- R6: Taking an event source clears its flag. Writing a 1 to bit i of register 0 also clears flag i, and bits written as 0 are left alone.
- R7: An event flag stays set while its enable or the global enable is 0. It is served later, in priority order, once both are 1.
- R8: Sources marked in `LEVEL_MASK` keep no flag. Register 0 shows their live input, and they request only while that input is high.
- R9: After a `retiDone` pulse, `irqReq` stays low until `instrDone` is seen in a later cycle.
- R10: If an event and a write-one-to-clear (or a take) hit the same flag in the same cycle, the flag stays set.
- R11: `irqAck` while `irqReq` is low changes nothing: flags, the global enable and `vecAddr` all keep their values.
- R12: After reset the flags, the enables, both control bits, `vecAddr` and `irqReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEvent | input | NUM_SRC | Event strobes (event sources) or live conditions (level sources) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 flags, 1 enables, 2 control |
| regWrData | input | NUM_SRC | Register write data |
| regRdData | output | NUM_SRC | Combinational read of the selected register |
| irqAck | input | 1 | Core takes the current request |
| retiDone | input | 1 | Core executed a return from interrupt |
| instrDone | input | 1 | Core completed an instruction |
| irqReq | output | 1 | Interrupt request to the core |
| vecAddr | output | ADDR_W | Vector captured at the last take |

## Verification
The hardest state to reach from the ports is the return holdoff with a source already waiting. To get there, a flag has to be latched while the global enable is off, then a return pulse has to arrive, and the completed-instruction strobe has to be held back for several cycles, including the case where it arrives in the very cycle of the return. Directed sequences build exactly that order of events. A seeded random phase then mixes returns, acknowledges, clears and events in the same cycles, and a bench model built from the requirements predicts every request, vector and register read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic take;
    logic flagClr;
    logic enWr;
    logic vecSel;
  } irqStrobes_t;

  typedef enum logic [1:0] {
    REG_FLAGS  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } regSel_e;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ALT_BASE = 16'h1C00,
  parameter int ENTRY_WORDS = 2,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] wrData,
  input  irqStrobes_t        strobes,
  output logic               anyCand,
  output logic [NUM_SRC-1:0] pendView,
  output logic [NUM_SRC-1:0] enView,
  output logic [ADDR_W-1:0]  vecAddr
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_SRC-1:0] EVENT_MASK = ~LEVEL_MASK;
  localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

  logic [NUM_SRC-1:0] flagQ, flagD, enQ, cand, selOH, clrTake, clrSw;
  logic [IDX_W-1:0]   selIdx;
  logic [ADDR_W-1:0]  vecBase, vecOffs, vecNext;

  assign pendView = (flagQ & EVENT_MASK) | (srcEvent & LEVEL_MASK);
  assign enView   = enQ;
  assign cand     = pendView & enQ;
  assign anyCand  = |cand;

  // Lowest set bit wins: isolate it, and find its index.
  assign selOH = cand & (~cand + ONE);

  always_comb begin
    selIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) selIdx = IDX_W'(i);
    end
  end

  assign clrTake = strobes.take    ? selOH  : '0;
  assign clrSw   = strobes.flagClr ? wrData : '0;
  // A new event overrides any clear in the same cycle.
  assign flagD   = ((flagQ & ~clrTake & ~clrSw) | srcEvent) & EVENT_MASK;

  assign vecBase = strobes.vecSel ? ALT_BASE : '0;
  assign vecOffs = ADDR_W'((32'(selIdx) + 32'd1) * 32'(ENTRY_WORDS));
  assign vecNext = vecBase + vecOffs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= '0;
      enQ     <= '0;
      vecAddr <= '0;
    end else begin
      flagQ <= flagD;
      if (strobes.enWr) enQ <= wrData;
      if (strobes.take) vecAddr <= vecNext;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gFlagChk
      if (!LEVEL_MASK[g]) begin : gEvt
        p_take_clears_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
          (strobes.take && selOH[g] && !srcEvent[g]) |=> !pendView[g]);
        p_event_beats_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
          (srcEvent[g] && (strobes.flagClr || strobes.take)) |=> pendView[g]);
      end
    end
  endgenerate

  p_vector_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.take |=> $stable(vecAddr));
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [1:0]         ctrlWrData,
  input  logic               irqAck,
  input  logic               retiDone,
  input  logic               instrDone,
  input  logic               anyCand,
  input  logic [NUM_SRC-1:0] pendView,
  input  logic [NUM_SRC-1:0] enView,
  output irqStrobes_t        strobes,
  output logic               irqReq,
  output logic [NUM_SRC-1:0] regRdData
);
  logic    gieQ, vselQ, holdQ, take, ctrlWr;
  regSel_e sel;

  assign sel    = regSel_e'(regAddr);
  assign ctrlWr = regWrEn && (sel == REG_CTRL);
  assign irqReq = gieQ && !holdQ && anyCand;
  assign take   = irqAck && irqReq;

  assign strobes.take    = take;
  assign strobes.flagClr = regWrEn && (sel == REG_FLAGS);
  assign strobes.enWr    = regWrEn && (sel == REG_ENABLE);
  assign strobes.vecSel  = vselQ;

  always_comb begin
    unique case (sel)
      REG_FLAGS:  regRdData = pendView;
      REG_ENABLE: regRdData = enView;
      REG_CTRL:   regRdData = {{(NUM_SRC-2){1'b0}}, vselQ, gieQ};
      default:    regRdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gieQ  <= 1'b0;
      vselQ <= 1'b0;
      holdQ <= 1'b0;
    end else begin
      if (take)          gieQ <= 1'b0;
      else if (retiDone) gieQ <= 1'b1;
      else if (ctrlWr)   gieQ <= ctrlWrData[0];
      if (ctrlWr) vselQ <= ctrlWrData[1];
      // The instruction must finish after the return cycle.
      if (retiDone)       holdQ <= 1'b1;
      else if (instrDone) holdQ <= 1'b0;
    end
  end

  p_req_needs_gie_r1: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> regRdData == regRdData && gieQ);
  p_take_drops_gie_r4: assert property (@(posedge clk) disable iff (!rstN)
    take |=> !gieQ);
  p_return_sets_gie_r5: assert property (@(posedge clk) disable iff (!rstN)
    (retiDone && !take) |=> gieQ);
  p_return_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    retiDone |=> !irqReq);
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ALT_BASE = 16'h1C00,
  parameter int ENTRY_WORDS = 2,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic               irqAck,
  input  logic               retiDone,
  input  logic               instrDone,
  output logic               irqReq,
  output logic [ADDR_W-1:0]  vecAddr
);
  irqStrobes_t        strobes;
  logic               anyCand;
  logic [NUM_SRC-1:0] pendView, enView;

  irq_control #(.NUM_SRC(NUM_SRC)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .ctrlWrData(regWrData[1:0]), .irqAck(irqAck), .retiDone(retiDone),
    .instrDone(instrDone), .anyCand(anyCand), .pendView(pendView),
    .enView(enView), .strobes(strobes), .irqReq(irqReq), .regRdData(regRdData)
  );

  irq_datapath #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ALT_BASE(ALT_BASE),
    .ENTRY_WORDS(ENTRY_WORDS), .LEVEL_MASK(LEVEL_MASK)
  ) dp_i (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .wrData(regWrData),
    .strobes(strobes), .anyCand(anyCand), .pendView(pendView),
    .enView(enView), .vecAddr(vecAddr)
  );
endmodule

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] ALT = 16'h1C00;
  localparam int EW = 2;
  localparam logic [N-1:0] LVL = 8'hC0;

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] srcEvent = '0, regWrData = '0, regRdData;
  logic regWrEn = 1'b0, irqAck = 1'b0, retiDone = 1'b0, instrDone = 1'b0, irqReq;
  logic [1:0] regAddr = '0;
  logic [AW-1:0] vecAddr;

  // staged stimulus
  logic [N-1:0] sEv = '0, sData = '0;
  logic sWr = 0, sAck = 0, sReti = 0, sInstr = 0;
  logic [1:0] sAddr = '0;

  // reference state
  logic [N-1:0] mFlag = '0, mEn = '0;
  logic mGie = 0, mVsel = 0, mHold = 0;
  logic [AW-1:0] mVec = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_unit #(.NUM_SRC(N), .ADDR_W(AW), .ALT_BASE(ALT), .ENTRY_WORDS(EW),
                    .LEVEL_MASK(LVL)) dut_i (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqAck(irqAck), .retiDone(retiDone), .instrDone(instrDone),
    .irqReq(irqReq), .vecAddr(vecAddr));

  function automatic int lowIdx(logic [N-1:0] c);
    for (int i = 0; i < N; i++) if (c[i]) return i;
    return 0;
  endfunction

  function automatic logic [AW-1:0] vecOf(int idx, logic vs);
    return (vs ? ALT : '0) + AW'((idx + 1) * EW);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    logic [N-1:0] pend, cand, expRd, takeMask, clrMask;
    logic eReq, take;
    int idx;
    @(negedge clk);
    srcEvent = sEv; regWrEn = sWr; regAddr = sAddr; regWrData = sData;
    irqAck = sAck; retiDone = sReti; instrDone = sInstr;
    #1;
    pend = (mFlag & ~LVL) | (sEv & LVL);
    cand = pend & mEn;
    eReq = mGie && !mHold && (cand != 0);
    idx  = lowIdx(cand);
    case (sAddr)
      2'd0: expRd = pend;
      2'd1: expRd = mEn;
      2'd2: expRd = {{(N-2){1'b0}}, mVsel, mGie};
      default: expRd = '0;
    endcase
    chk(tag, "irqReq", 32'(irqReq), 32'(eReq));
    chk(tag, "vecAddr", 32'(vecAddr), 32'(mVec));
    chk(tag, "regRdData", 32'(regRdData), 32'(expRd));
    @(posedge clk);
    take     = sAck && eReq;
    takeMask = take ? (N'(1) << idx) : '0;
    clrMask  = (sWr && sAddr == 2'd0) ? sData : '0;
    if (take) mVec = vecOf(idx, mVsel);
    mFlag = ((mFlag & ~takeMask & ~clrMask) | sEv) & ~LVL;
    if (sWr && sAddr == 2'd1) mEn = sData;
    if (take) mGie = 0;
    else if (sReti) mGie = 1;
    else if (sWr && sAddr == 2'd2) mGie = sData[0];
    if (sWr && sAddr == 2'd2) mVsel = sData[1];
    if (sReti) mHold = 1;
    else if (sInstr) mHold = 0;
  endtask

  task automatic idle();
    sEv = '0; sWr = 0; sAck = 0; sReti = 0; sInstr = 0; sData = '0;
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d, string tag);
    idle(); sWr = 1; sAddr = a; sData = d; step(tag); idle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // reset state
    for (int a = 0; a < 3; a++) begin idle(); sAddr = 2'(a); step("R12"); end
    // remembered flag while disabled, then served
    idle(); sEv = 8'h02; step("R7");
    idle(); sAddr = 0; repeat (3) step("R7");
    wr(2'd1, 8'h02, "R7");
    wr(2'd2, 8'h01, "R7");
    sAck = 1; step("R7"); idle();
    sAddr = 2; step("R4"); sAddr = 0; step("R6");
    // priority among simultaneous events
    sEv = 8'h28; step("R2"); idle();
    wr(2'd1, 8'h3F, "R2");
    wr(2'd2, 8'h01, "R2");
    sAck = 1; step("R2"); idle(); step("R2");
    // alternate base
    wr(2'd2, 8'h03, "R3");
    sAck = 1; step("R3"); idle(); sAddr = 2; step("R3");
    // return holdoff with a waiting source
    sEv = 8'h10; step("R9"); idle();
    sReti = 1; sInstr = 1; step("R5"); idle();
    sAddr = 2; repeat (3) step("R9");
    sInstr = 1; step("R9"); idle(); step("R9");
    sAck = 1; step("R9"); idle();
    // acknowledge with no request
    sAck = 1; sAddr = 0; step("R11"); step("R11"); idle(); step("R11");
    // level sources
    wr(2'd1, 8'h40, "R8");
    wr(2'd2, 8'h01, "R8");
    sEv = 8'h40; sAddr = 0; step("R8"); step("R8"); idle(); step("R8");
    wr(2'd2, 8'h00, "R8");
    sEv = 8'h80; step("R8"); idle(); step("R8");
    wr(2'd1, 8'hC0, "R8");
    wr(2'd2, 8'h01, "R8"); step("R8");
    // event vs software clear
    sEv = 8'h04; step("R10"); idle();
    sWr = 1; sAddr = 0; sData = 8'h04; sEv = 8'h04; step("R10"); idle();
    sAddr = 0; step("R10");
    wr(2'd0, 8'h04, "R6"); sAddr = 0; step("R6");
    // seeded random mix
    for (int c = 0; c < 4000; c++) begin
      sEv    = N'($urandom & $urandom & $urandom);
      sWr    = ($urandom % 6) == 0;
      sAddr  = 2'($urandom);
      sData  = N'($urandom);
      sAck   = $urandom % 2;
      sReti  = ($urandom % 15) == 0;
      sInstr = $urandom % 2;
      step("R1");
    end
    idle(); step("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule